// File: doc/BRIEF.md
# I2C Register Target with Two-Byte Subaddress

This block is an I2C target that answers at a single 7-bit bus address and reaches a large internal register space through a 16-bit subaddress. The host sends the subaddress as two bytes, upper byte first, and then either sends data bytes or issues a repeated start and reads them back. The subaddress steps forward by one after every data byte, so a burst covers consecutive registers. Every register is 8 bits wide.

SCL and SDA are sampled with the system clock through synchronizers. Start and stop conditions are recovered from the sampled lines. The serial data output is open-drain: the block only pulls SDA low or lets it go. Storage is reached over a plain synchronous register-file port. A write is a one-cycle strobe. A read is a one-cycle request, and the data is returned on the next clock.

The subaddress is decoded into one of eighteen register-map regions and an offset within that region. Space that falls in no region is still acknowledged on the bus. Writes there are dropped, and reads there return zero.

Top module: `i2cs_regslave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) puts the target into address reception with a fresh bit count, also in the middle of a byte or a burst. A repeated start keeps the subaddress already loaded.
- R2: The first byte after a start is the 7-bit device address (default 0x0D), sent MSB first, followed by the direction bit. On a match the target pulls SDA low for the ninth clock. On a mismatch it leaves SDA released and ignores all bytes until the next start. Byte 0x1A selects a write and 0x1B a read.
- R3: In a write, the second byte sets subaddress bits 15:8 and the third sets bits 7:0. Each following byte produces a single-cycle rf_we with rf_addr equal to the current subaddress and rf_wdata equal to that byte. Every one of these bytes is acknowledged.
- R4: After every data byte the subaddress increments by one, carrying from the low byte into the high byte. A burst therefore writes consecutive registers.
- R5: After a repeated start with byte 0x1B, the target sends the register at the current subaddress MSB first and then increments the subaddress. A host ACK (SDA low on the ninth clock) starts the next byte. A host NACK releases SDA and ends the read.
- R6: Region decode of rf_addr. Upper bytes 0x1A and 0x1B give rf_map 0, and rf_offset is {addr[8], addr[7:0]}. The upper bytes E0, E2, E3, E4, E6, E8, E9, EC, EE, F0, F2, F3, F4, F6, F8, FA and FB give rf_map 1 through 17 in that order, with rf_offset = {0, addr[7:0]}. rf_hit is high for all of these.
- R7: For any other upper byte, rf_hit is 0 and rf_map is 31. Data bytes written there are acknowledged but cause no rf_we. Reads there issue no rf_re and return 0x00.
- R8: A stop condition (SDA rising while SCL is high) returns the target to idle and ends any burst. After a stop, clocked bytes without a new start are not acknowledged and write nothing. Out of reset the target is idle, with sda_oe, rf_we and rf_re all low.
- R9: sda_oe = 1 means SDA is pulled low, and sda_oe = 0 means SDA is released. sda_oe changes only while the sampled SCL is low.
- R10: rf_re is a single-cycle pulse. The target takes rf_rdata on the clock after that pulse. rf_we and rf_re are never high together, and neither is high while rf_hit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rf_addr | output | 16 | Current subaddress |
| rf_map | output | 5 | Decoded region index, 31 when unmapped |
| rf_offset | output | 9 | Offset within the region |
| rf_hit | output | 1 | rf_addr lies in a mapped region |
| rf_we | output | 1 | Single-cycle write strobe |
| rf_re | output | 1 | Single-cycle read request |
| rf_wdata | output | 8 | Write data |
| rf_rdata | input | 8 | Read data, valid the clock after rf_re |

## Verification
The bench sweeps all 256 upper subaddress bytes with a single-byte write. Each write must strobe, with the right region and offset, exactly when the byte is mapped. A decoder that slipped one region or lost the 512-byte region's ninth offset bit would report the wrong map or offset, and one that stored to unmapped space would show an extra write. A burst that runs from the end of the 512-byte region into unmapped space checks the increment carry and the drop of writes there. A read that crosses from a mapped page into an unmapped one must return model data and then zero. The bench also aborts a transfer mid-byte with a repeated start, clocks bytes after a stop, and addresses the wrong device. A target that kept its bit count across a start, stayed active after a stop, or acknowledged a foreign address would show stray writes or acknowledges.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   localparam int BYTE_W    = 8;
   localparam int SUB_W     = 16;
   localparam int NUM_MAPS  = 18;
   localparam int MAP_SEL_W = 5;
   localparam int OFF_W     = BYTE_W + 1;
   localparam logic [MAP_SEL_W-1:0] MAP_NONE = '1;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_SUBH, ST_SUBL, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK
   } phase_t;

   // Upper subaddress byte of each region; index 0 spans two pages.
   function automatic logic [BYTE_W-1:0] map_page(input int idx);
      case (idx)
         0:  return 8'h1A;
         1:  return 8'hE0;
         2:  return 8'hE2;
         3:  return 8'hE3;
         4:  return 8'hE4;
         5:  return 8'hE6;
         6:  return 8'hE8;
         7:  return 8'hE9;
         8:  return 8'hEC;
         9:  return 8'hEE;
         10: return 8'hF0;
         11: return 8'hF2;
         12: return 8'hF3;
         13: return 8'hF4;
         14: return 8'hF6;
         15: return 8'hF8;
         16: return 8'hFA;
         default: return 8'hFB;
      endcase
   endfunction
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2cs_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_i};
         sda_q <= {sda_q[STAGES-2:0], sda_i};
         scl_p <= scl_q[STAGES-1];
         sda_p <= sda_q[STAGES-1];
      end
   end

   assign scl_s     = scl_q[STAGES-1];
   assign sda_s     = sda_q[STAGES-1];
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_map_decode.sv
module i2cs_map_decode
   import i2cs_pkg::*;
(
   input  logic [SUB_W-1:0]     addr,
   output logic                 hit,
   output logic [MAP_SEL_W-1:0] sel,
   output logic [OFF_W-1:0]     offset
);
   logic [BYTE_W-1:0]   hb, lb;
   logic [NUM_MAPS-1:0] match;

   assign hb = addr[SUB_W-1:BYTE_W];
   assign lb = addr[BYTE_W-1:0];

   for (genvar g = 0; g < NUM_MAPS; g++) begin : g_region
      if (g == 0) begin : g_wide
         assign match[g] = (hb[BYTE_W-1:1] == map_page(g)[BYTE_W-1:1]);
      end else begin : g_page
         assign match[g] = (hb == map_page(g));
      end
   end

   always_comb begin
      sel = MAP_NONE;
      for (int i = NUM_MAPS - 1; i >= 0; i--) begin
         if (match[i]) sel = MAP_SEL_W'(i);
      end
   end

   assign hit    = |match;
   assign offset = match[0] ? {hb[0], lb} : {1'b0, lb};
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
   import i2cs_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h0D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic              sub_hit,
   input  logic [BYTE_W-1:0] rf_rdata,
   output logic              sda_oe,
   output logic              rf_we,
   output logic              rf_re,
   output logic [BYTE_W-1:0] rf_wdata,
   output logic [SUB_W-1:0]  sub
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   phase_t            st, nxt;
   logic [BYTE_W-1:0] rx, tx;
   logic [CNT_W-1:0]  bits;
   logic              re_q, m_ack, inc_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         nxt      <= ST_IDLE;
         rx       <= '0;
         tx       <= '0;
         bits     <= '0;
         re_q     <= 1'b0;
         m_ack    <= 1'b0;
         inc_pend <= 1'b0;
         sda_oe   <= 1'b0;
         rf_we    <= 1'b0;
         rf_re    <= 1'b0;
         rf_wdata <= '0;
         sub      <= '0;
      end else begin
         rf_we <= 1'b0;
         rf_re <= 1'b0;
         re_q  <= rf_re;
         if (re_q) tx <= rf_rdata;

         if (start_det) begin
            st       <= ST_ADDR;
            bits     <= '0;
            sda_oe   <= 1'b0;
            inc_pend <= 1'b0;
         end else if (stop_det) begin
            st       <= ST_IDLE;
            sda_oe   <= 1'b0;
            inc_pend <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_SUBH, ST_SUBL, ST_WDATA: begin
                  if (scl_rise && bits != FULL) begin
                     rx   <= {rx[BYTE_W-2:0], sda_s};
                     bits <= bits + 1'b1;
                  end else if (scl_fall && bits == FULL) begin
                     bits <= '0;
                     case (st)
                        ST_ADDR: begin
                           if (rx[BYTE_W-1:1] == DEV_ADDR) begin
                              sda_oe <= 1'b1;
                              st     <= ST_ACK;
                              if (rx[0]) begin
                                 nxt <= ST_RDATA;
                                 if (sub_hit) rf_re <= 1'b1;
                                 else         tx    <= '0;
                              end else begin
                                 nxt <= ST_SUBH;
                              end
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        ST_SUBH: begin
                           sub[SUB_W-1:BYTE_W] <= rx;
                           sda_oe <= 1'b1;
                           st     <= ST_ACK;
                           nxt    <= ST_SUBL;
                        end
                        ST_SUBL: begin
                           sub[BYTE_W-1:0] <= rx;
                           sda_oe <= 1'b1;
                           st     <= ST_ACK;
                           nxt    <= ST_WDATA;
                        end
                        default: begin
                           rf_we    <= sub_hit;
                           rf_wdata <= rx;
                           inc_pend <= 1'b1;
                           sda_oe   <= 1'b1;
                           st       <= ST_ACK;
                           nxt      <= ST_WDATA;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     st   <= nxt;
                     bits <= '0;
                     if (inc_pend) begin
                        sub      <= sub + 1'b1;
                        inc_pend <= 1'b0;
                     end
                     if (nxt == ST_RDATA) begin
                        sda_oe <= ~tx[BYTE_W-1];
                        tx     <= {tx[BYTE_W-2:0], 1'b0};
                     end else begin
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     bits <= bits + 1'b1;
                  end else if (scl_fall) begin
                     if (bits == FULL) begin
                        sda_oe <= 1'b0;
                        sub    <= sub + 1'b1;
                        st     <= ST_RACK;
                     end else begin
                        sda_oe <= ~tx[BYTE_W-1];
                        tx     <= {tx[BYTE_W-2:0], 1'b0};
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     m_ack <= ~sda_s;
                     if (!sda_s) begin
                        if (sub_hit) rf_re <= 1'b1;
                        else         tx    <= '0;
                     end
                  end else if (scl_fall) begin
                     bits <= '0;
                     if (m_ack) begin
                        st     <= ST_RDATA;
                        sda_oe <= ~tx[BYTE_W-1];
                        tx     <= {tx[BYTE_W-2:0], 1'b0};
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2cs_regslave.sv
module i2cs_regslave
   import i2cs_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h0D,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   output logic                 sda_oe,
   output logic [SUB_W-1:0]     rf_addr,
   output logic [MAP_SEL_W-1:0] rf_map,
   output logic [OFF_W-1:0]     rf_offset,
   output logic                 rf_hit,
   output logic                 rf_we,
   output logic                 rf_re,
   output logic [BYTE_W-1:0]    rf_wdata,
   input  logic [BYTE_W-1:0]    rf_rdata
);
   if (DEV_ADDR < 7'h08 || DEV_ADDR > 7'h77) begin : g_bad_addr
      $error("i2cs_regslave: DEV_ADDR lies in a reserved address range");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2cs_map_decode u_dec (
      .addr   (rf_addr),
      .hit    (rf_hit),
      .sel    (rf_map),
      .offset (rf_offset)
   );

   i2cs_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_s     (sda_s),
      .sub_hit   (rf_hit),
      .rf_rdata  (rf_rdata),
      .sda_oe    (sda_oe),
      .rf_we     (rf_we),
      .rf_re     (rf_re),
      .rf_wdata  (rf_wdata),
      .sub       (rf_addr)
   );
endmodule

// File: rtl/i2cs_regslave_chk.sv
module i2cs_regslave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       stop_det,
   input logic       sda_oe,
   input logic       rf_we,
   input logic       rf_re,
   input logic       rf_hit,
   input logic [4:0] rf_map
);
   // R9: the data line is only switched while the sampled clock is low
   p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

   // R8: a stop leaves the line released and writes nothing
   p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe && !rf_we));

   // R7: no storage access into unmapped space
   p_no_we_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> rf_hit);
   p_no_re_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rf_re |-> rf_hit);

   // R10: read request is a single pulse and never coincides with a write
   p_re_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rf_re |=> !rf_re);
   p_we_re_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(rf_we && rf_re));

   // R3: write strobe lasts one cycle
   p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we);

   // R6: a mapped address selects one of the eighteen regions
   p_sel_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rf_hit |-> (rf_map < 5'd18));
endmodule

bind i2cs_regslave i2cs_regslave_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .stop_det (stop_det),
   .sda_oe   (sda_oe),
   .rf_we    (rf_we),
   .rf_re    (rf_re),
   .rf_hit   (rf_hit),
   .rf_map   (rf_map)
);

// File: tb/tb_i2cs_regslave.sv
`timescale 1ns/1ps
module tb_i2cs_regslave;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe, rf_hit, rf_we, rf_re;
   logic [15:0] rf_addr;
   logic [4:0]  rf_map;
   logic [8:0]  rf_offset;
   logic [7:0]  rf_wdata;
   logic [7:0]  rf_rdata = 8'h00;
   logic        sda_line;

   always #5 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   i2cs_regslave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .rf_addr(rf_addr), .rf_map(rf_map),
      .rf_offset(rf_offset), .rf_hit(rf_hit), .rf_we(rf_we),
      .rf_re(rf_re), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int          wr_n = 0;
   int          rd_n = 0;
   logic [15:0] wa;
   logic [7:0]  wd;
   logic [4:0]  wm;
   logic [8:0]  wo;

   function automatic logic [7:0] model(input logic [15:0] a);
      return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
   endfunction

   function automatic int exp_sel(input logic [7:0] hb);
      case (hb)
         8'h1A, 8'h1B: return 0;
         8'hE0: return 1;   8'hE2: return 2;   8'hE3: return 3;
         8'hE4: return 4;   8'hE6: return 5;   8'hE8: return 6;
         8'hE9: return 7;   8'hEC: return 8;   8'hEE: return 9;
         8'hF0: return 10;  8'hF2: return 11;  8'hF3: return 12;
         8'hF4: return 13;  8'hF6: return 14;  8'hF8: return 15;
         8'hFA: return 16;  8'hFB: return 17;
         default: return 31;
      endcase
   endfunction

   always_ff @(posedge clk) begin
      if (rf_re) begin
         rf_rdata <= model(rf_addr);
         rd_n     <= rd_n + 1;
      end
      if (rf_we) begin
         wr_n <= wr_n + 1;
         wa   <= rf_addr;
         wd   <= rf_wdata;
         wm   <= rf_map;
         wo   <= rf_offset;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_c(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_x(input logic b, output logic seen);
      wait_c(4);
      sda_m = b;
      wait_c(2);
      scl_m = 1'b1;
      wait_c(3);
      seen = sda_line;
      wait_c(2);
      scl_m = 1'b0;
   endtask

   task automatic do_start();
      sda_m = 1'b1;
      wait_c(6);
      scl_m = 1'b1;
      wait_c(4);
      sda_m = 1'b0;
      wait_c(4);
      scl_m = 1'b0;
   endtask

   task automatic do_stop();
      wait_c(4);
      sda_m = 1'b0;
      wait_c(4);
      scl_m = 1'b1;
      wait_c(4);
      sda_m = 1'b1;
      wait_c(6);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_x(b[i], s);
      bit_x(1'b1, s);
      ack = !s;
   endtask

   task automatic recv_byte(input logic nack, output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_x(1'b1, s);
         v[i] = s;
      end
      bit_x(nack, s);
   endtask

   task automatic write1(input logic [15:0] a, input logic [7:0] d, output int acks);
      bit k;
      acks = 0;
      do_start();
      send_byte(8'h1A, k);  acks += int'(k);
      send_byte(a[15:8], k); acks += int'(k);
      send_byte(a[7:0], k);  acks += int'(k);
      send_byte(d, k);       acks += int'(k);
      do_stop();
   endtask

   initial begin
      int          acks, w0, r0, exp_m;
      bit          k;
      logic        s;
      logic [7:0]  v;
      logic [8:0]  exp_o;

      wait_c(5);
      // R8 / R9 / R10: reset state
      chk(sda_oe == 1'b0, "R9 reset sda_oe", sda_oe, 0);
      chk(rf_we == 1'b0 && rf_re == 1'b0, "R8 reset strobes", {rf_we, rf_re}, 0);
      rst_n = 1'b1;
      wait_c(5);

      // R3 / R6: single write into a 256-byte region
      w0 = wr_n;
      write1(16'hE4A0, 8'h3C, acks);
      chk(acks == 4, "R3 write acks", acks, 4);
      chk(wr_n == w0 + 1, "R3 write count", wr_n - w0, 1);
      chk(wa == 16'hE4A0 && wd == 8'h3C, "R3 write addr/data", {wa, wd}, 24'hE4A03C);
      chk(wm == 5'd4 && wo == 9'h0A0, "R6 region/offset", {wm, wo}, {5'd4, 9'h0A0});

      // R7: unmapped write acknowledged but dropped
      w0 = wr_n;
      write1(16'h59AF, 8'hFF, acks);
      chk(acks == 4, "R7 unmapped acks", acks, 4);
      chk(wr_n == w0, "R7 unmapped dropped", wr_n - w0, 0);

      // R4 / R6 / R7: burst from end of the wide region into unmapped space
      w0 = wr_n;
      acks = 0;
      do_start();
      send_byte(8'h1A, k); acks += int'(k);
      send_byte(8'h1B, k); acks += int'(k);
      send_byte(8'hFE, k); acks += int'(k);
      send_byte(8'h11, k); acks += int'(k);
      send_byte(8'h22, k); acks += int'(k);
      send_byte(8'h33, k); acks += int'(k);
      do_stop();
      chk(acks == 6, "R4 burst acks", acks, 6);
      chk(wr_n == w0 + 2, "R4 burst count", wr_n - w0, 2);
      chk(wa == 16'h1BFF && wd == 8'h22, "R4 burst last write", {wa, wd}, 24'h1BFF22);
      chk(wm == 5'd0 && wo == 9'h1FF, "R6 wide offset", {wm, wo}, {5'd0, 9'h1FF});

      // R2: foreign address is ignored
      w0 = wr_n;
      do_start();
      send_byte(8'h1C, k);
      chk(!k, "R2 foreign address no ack", k, 0);
      send_byte(8'hE0, k);
      chk(!k, "R2 ignored after mismatch", k, 0);
      send_byte(8'h00, k);
      send_byte(8'h77, k);
      do_stop();
      chk(wr_n == w0, "R2 no write after mismatch", wr_n - w0, 0);

      // R5 / R10: read burst with repeated start
      r0 = rd_n;
      do_start();
      send_byte(8'h1A, k);
      send_byte(8'hF3, k);
      send_byte(8'h10, k);
      do_start();
      send_byte(8'h1B, k);
      chk(k, "R2 read address ack", k, 1);
      recv_byte(1'b0, v);
      chk(v == model(16'hF310), "R5 R10 read byte 0", v, model(16'hF310));
      recv_byte(1'b0, v);
      chk(v == model(16'hF311), "R5 read byte 1", v, model(16'hF311));
      recv_byte(1'b1, v);
      chk(v == model(16'hF312), "R5 read byte 2", v, model(16'hF312));
      wait_c(8);
      chk(sda_oe == 1'b0, "R5 R9 released after NACK", sda_oe, 0);
      do_stop();
      chk(rd_n == r0 + 3, "R10 read request count", rd_n - r0, 3);

      // R7: read crossing into unmapped space returns zero
      r0 = rd_n;
      do_start();
      send_byte(8'h1A, k);
      send_byte(8'hE0, k);
      send_byte(8'hFF, k);
      do_start();
      send_byte(8'h1B, k);
      recv_byte(1'b0, v);
      chk(v == model(16'hE0FF), "R7 read last mapped byte", v, model(16'hE0FF));
      recv_byte(1'b1, v);
      chk(v == 8'h00, "R7 unmapped read zero", v, 0);
      do_stop();
      chk(rd_n == r0 + 1, "R7 no request unmapped", rd_n - r0, 1);

      // R1: start in the middle of a byte restarts address reception
      w0 = wr_n;
      do_start();
      send_byte(8'h1A, k);
      send_byte(8'hE6, k);
      for (int i = 0; i < 4; i++) bit_x(1'b1, s);
      do_start();
      acks = 0;
      send_byte(8'h1A, k); acks += int'(k);
      send_byte(8'hE8, k); acks += int'(k);
      send_byte(8'h05, k); acks += int'(k);
      send_byte(8'h77, k); acks += int'(k);
      do_stop();
      chk(acks == 4, "R1 acks after restart", acks, 4);
      chk(wr_n == w0 + 1 && wa == 16'hE805 && wd == 8'h77, "R1 write after restart",
          {wa, wd}, 24'hE80577);

      // R8: stop ends the burst; bytes without a start are ignored
      w0 = wr_n;
      do_start();
      send_byte(8'h1A, k);
      send_byte(8'hE9, k);
      send_byte(8'h00, k);
      send_byte(8'h44, k);
      do_stop();
      scl_m = 1'b0;
      send_byte(8'h1A, k);
      chk(!k, "R8 no ack after stop", k, 0);
      send_byte(8'h55, k);
      chk(!k, "R8 data ignored after stop", k, 0);
      wait_c(4);
      scl_m = 1'b1;
      wait_c(6);
      chk(wr_n == w0 + 1, "R8 write count", wr_n - w0, 1);

      // R6 / R7: sweep all upper subaddress bytes
      for (int hb = 0; hb < 256; hb++) begin
         w0 = wr_n;
         write1({8'(hb), 8'h5C}, ~8'(hb), acks);
         exp_m = exp_sel(8'(hb));
         exp_o = (exp_m == 0) ? {hb[0], 8'h5C} : {1'b0, 8'h5C};
         if (exp_m == 31)
            chk(acks == 4 && wr_n == w0, "R7 sweep unmapped", wr_n - w0, 0);
         else
            chk(acks == 4 && wr_n == w0 + 1 && int'(wm) == exp_m && wo == exp_o &&
                wd == ~8'(hb), "R6 sweep mapped", {wm, wo}, {5'(exp_m), exp_o});
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule